// File: doc/BRIEF.md
# Paired Timed Automata with Rendezvous Channel

This block runs two small timed automata in hardware against one shared notion of time. A tick generator divides the core clock into sampling periods of `SUB_CYCLES` core cycles. It advances a single free-running global time counter once per period. Each automaton does not run its own clock counter. Instead it keeps one capture register that records the global time whenever its clock is reset. Its clock value is the modular difference between the global time and that capture.

The two automata meet through one rendezvous channel. Each automaton raises a request while it waits for its partner. The channel ANDs the requests and registers the result for one cycle, which breaks the combinational loop. The registered result goes back to both automata as the acknowledge. On an acknowledge, an automaton drops its request, restarts its clock and moves to its holding location. It stays there until its clock reaches its guard value, then returns to wait for the next rendezvous.

Automata transitions are evaluated on every core cycle of a period except the cycle that advances time. Several evaluations therefore fall inside one time step, so a chain of immediate steps can settle before time moves on.

Top module: `ta_pair_core`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is as follows. Global time and both clock values are 0, and both automata are in the waiting location (code 2'b01). The acknowledge and `tick_o` are low.
- R2: `tick_o` is high for exactly one core cycle in every `SUB_CYCLES` cycles. The first pulse is in cycle `SUB_CYCLES-1` after reset. Global time rises by one on the edge that ends a tick cycle and holds on every other edge.
- R3: Global time wraps modulo 2^`TIME_W`. Each clock value output equals (global time minus capture) modulo 2^`TIME_W`, and it stays correct across the wrap.
- R4: On every edge, the acknowledge takes the AND of both request outputs from the cycle before. Both automata see this same acknowledge.
- R5: In the waiting location an automaton holds its request high while the acknowledge is low. With the acknowledge high, the request is low. On an evaluation edge with the acknowledge high, the automaton captures global time, so its clock value becomes 0, and it moves to the holding location (code 2'b10).
- R6: In the holding location, on an evaluation edge where the clock value equals that automaton's guard (`GUARD_A` or `GUARD_B`), the automaton returns to the waiting location. On any other evaluation edge it stays put.
- R7: On the edge that ends a tick cycle, no automaton changes location or capture.
- R8: A location code outside the two legal ones drives the automaton to the fault code 2'b11, and the fault code is kept. Starting from reset with legal codes, no automaton ever reaches 2'b11 or 2'b00.
- R9: With unequal guards, the automaton that finishes first waits with its request high until the other returns. Both then leave the waiting location on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_o | output | 1 | High in the last core cycle of each sampling period |
| now_time_o | output | TIME_W | Global time counter |
| chan_ack_o | output | 1 | Registered rendezvous acknowledge, shared by both automata |
| req_a_o | output | 1 | Channel request of automaton A |
| req_b_o | output | 1 | Channel request of automaton B |
| loc_a_o | output | 2 | Location code of automaton A (01 wait, 10 hold, 11 fault) |
| loc_b_o | output | 2 | Location code of automaton B |
| clkval_a_o | output | TIME_W | Clock value of automaton A |
| clkval_b_o | output | TIME_W | Clock value of automaton B |

## Verification
The assertions check several things on every cycle. Time may only move on a tick, and ticks never fall back to back. The acknowledge is checked against the prior cycle's requests. On every evaluation edge they check the capture-and-enter-hold step and the guard release. They also check that no location changes on a tick edge and that neither automaton ever leaves the legal codes. Some behaviour needs whole scenarios instead, and only the bench shows it. This covers the wrap of the global counter with clock values still correct after it. It also covers the exact period of the rendezvous cycle, and the waiting of the faster automaton when the two guards differ.

// File: rtl/ta_pair_pkg.sv
package ta_pair_pkg;

    localparam int TA_COUNT = 2;

    typedef enum logic [1:0] {
        LOC_WAIT  = 2'b01,
        LOC_HOLD  = 2'b10,
        LOC_FAULT = 2'b11
    } ta_loc_e;

    typedef struct packed {
        ta_loc_e loc;
        logic    capture;
    } ta_step_t;

    // One evaluation of the automaton's location logic.
    function automatic ta_step_t ta_step(
        input ta_loc_e cur,
        input logic    eval,
        input logic    ack,
        input logic    at_guard
    );
        ta_step_t s;
        s.loc     = cur;
        s.capture = 1'b0;
        if (eval) begin
            case (cur)
                LOC_WAIT: begin
                    if (ack) begin
                        s.loc     = LOC_HOLD;
                        s.capture = 1'b1;
                    end
                end
                LOC_HOLD: begin
                    if (at_guard) s.loc = LOC_WAIT;
                end
                LOC_FAULT: s.loc = LOC_FAULT;
                default:   s.loc = LOC_FAULT;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ta_tick_gen.sv
module ta_tick_gen #(
    parameter int TIME_W     = 16,
    parameter int SUB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic              tick_o,
    output logic              eval_o,
    output logic [TIME_W-1:0] now_o
);
    localparam int SUB_W = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_CYCLES - 1);

    logic [SUB_W-1:0]  sub_q;
    logic [TIME_W-1:0] now_q;
    logic              last_sub;

    assign last_sub = (sub_q == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            now_q <= '0;
        end else if (last_sub) begin
            sub_q <= '0;
            now_q <= now_q + TIME_W'(1);
        end else begin
            sub_q <= sub_q + SUB_W'(1);
        end
    end

    assign tick_o = last_sub;
    assign eval_o = !last_sub;
    assign now_o  = now_q;
endmodule

// File: rtl/ta_sync_channel.sv
module ta_sync_channel #(
    parameter int PARTIES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PARTIES-1:0] req_i,
    output logic               ack_o
);
    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= &req_i;
    end

    assign ack_o = ack_q;
endmodule

// File: rtl/ta_automaton.sv
module ta_automaton
    import ta_pair_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int GUARD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_i,
    input  logic              ack_i,
    input  logic [TIME_W-1:0] now_i,
    output logic [1:0]        loc_o,
    output logic              req_o,
    output logic [TIME_W-1:0] clkval_o
);
    localparam logic [TIME_W-1:0] GUARD_V = TIME_W'(GUARD);

    ta_loc_e           loc_q;
    logic [TIME_W-1:0] cap_q;
    logic [TIME_W-1:0] elapsed;
    logic              at_guard;
    ta_step_t          nxt;

    assign elapsed  = now_i - cap_q;
    assign at_guard = (elapsed == GUARD_V);

    always_comb begin
        nxt = ta_step(loc_q, eval_i, ack_i, at_guard);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q <= LOC_WAIT;
            cap_q <= '0;
        end else begin
            loc_q <= nxt.loc;
            if (nxt.capture) cap_q <= now_i;
        end
    end

    assign req_o    = (loc_q == LOC_WAIT) && !ack_i;
    assign loc_o    = loc_q;
    assign clkval_o = elapsed;
endmodule

// File: rtl/ta_pair_core.sv
module ta_pair_core
    import ta_pair_pkg::*;
#(
    parameter int TIME_W     = 16,
    parameter int SUB_CYCLES = 4,
    parameter int GUARD_A    = 2,
    parameter int GUARD_B    = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              tick_o,
    output logic [TIME_W-1:0] now_time_o,
    output logic              chan_ack_o,
    output logic              req_a_o,
    output logic              req_b_o,
    output logic [1:0]        loc_a_o,
    output logic [1:0]        loc_b_o,
    output logic [TIME_W-1:0] clkval_a_o,
    output logic [TIME_W-1:0] clkval_b_o
);
    logic              tick;
    logic              eval;
    logic [TIME_W-1:0] now_time;
    logic              chan_ack;
    logic [TA_COUNT-1:0] req_v;
    logic [1:0]        loc_w    [TA_COUNT];
    logic [TIME_W-1:0] clkval_w [TA_COUNT];

    ta_tick_gen #(
        .TIME_W    (TIME_W),
        .SUB_CYCLES(SUB_CYCLES)
    ) tick_i (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick),
        .eval_o(eval),
        .now_o (now_time)
    );

    ta_sync_channel #(
        .PARTIES(TA_COUNT)
    ) chan_i (
        .clk  (clk),
        .rst  (rst),
        .req_i(req_v),
        .ack_o(chan_ack)
    );

    for (genvar i = 0; i < TA_COUNT; i++) begin : g_ta
        localparam int G = (i == 0) ? GUARD_A : GUARD_B;
        logic req_w;

        ta_automaton #(
            .TIME_W(TIME_W),
            .GUARD (G)
        ) ta_i (
            .clk     (clk),
            .rst     (rst),
            .eval_i  (eval),
            .ack_i   (chan_ack),
            .now_i   (now_time),
            .loc_o   (loc_w[i]),
            .req_o   (req_w),
            .clkval_o(clkval_w[i])
        );

        assign req_v[i] = req_w;
    end

    assign tick_o     = tick;
    assign now_time_o = now_time;
    assign chan_ack_o = chan_ack;
    assign req_a_o    = req_v[0];
    assign req_b_o    = req_v[1];
    assign loc_a_o    = loc_w[0];
    assign loc_b_o    = loc_w[1];
    assign clkval_a_o = clkval_w[0];
    assign clkval_b_o = clkval_w[1];
endmodule

// File: rtl/ta_pair_chk.sv
module ta_pair_chk #(
    parameter int TIME_W  = 16,
    parameter int GUARD_A = 2,
    parameter int GUARD_B = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_o,
    input logic [TIME_W-1:0] now_time_o,
    input logic              chan_ack_o,
    input logic              req_a_o,
    input logic              req_b_o,
    input logic [1:0]        loc_a_o,
    input logic [1:0]        loc_b_o,
    input logic [TIME_W-1:0] clkval_a_o,
    input logic [TIME_W-1:0] clkval_b_o
);
    localparam logic [1:0] C_WAIT = 2'b01;
    localparam logic [1:0] C_HOLD = 2'b10;
    localparam logic [TIME_W-1:0] GA = TIME_W'(GUARD_A);
    localparam logic [TIME_W-1:0] GB = TIME_W'(GUARD_B);

    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    a_r2_time_step: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (now_time_o == $past(now_time_o) + TIME_W'(1)));

    a_r2_time_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(now_time_o));

    a_r4_ack_and: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (chan_ack_o == $past(req_a_o && req_b_o)));

    a_r5_capture_a: assert property (@(posedge clk) disable iff (rst)
        (loc_a_o == C_WAIT && chan_ack_o && !tick_o) |=> (loc_a_o == C_HOLD && clkval_a_o == '0));

    a_r5_capture_b: assert property (@(posedge clk) disable iff (rst)
        (loc_b_o == C_WAIT && chan_ack_o && !tick_o) |=> (loc_b_o == C_HOLD && clkval_b_o == '0));

    a_r6_release_a: assert property (@(posedge clk) disable iff (rst)
        (loc_a_o == C_HOLD && clkval_a_o == GA && !tick_o) |=> (loc_a_o == C_WAIT));

    a_r6_release_b: assert property (@(posedge clk) disable iff (rst)
        (loc_b_o == C_HOLD && clkval_b_o == GB && !tick_o) |=> (loc_b_o == C_WAIT));

    a_r7_tick_freeze: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> ($stable(loc_a_o) && $stable(loc_b_o)));

    a_r8_legal_codes: assert property (@(posedge clk) disable iff (rst)
        (loc_a_o == C_WAIT || loc_a_o == C_HOLD) && (loc_b_o == C_WAIT || loc_b_o == C_HOLD));
endmodule

bind ta_pair_core ta_pair_chk #(
    .TIME_W (TIME_W),
    .GUARD_A(GUARD_A),
    .GUARD_B(GUARD_B)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_o    (tick_o),
    .now_time_o(now_time_o),
    .chan_ack_o(chan_ack_o),
    .req_a_o   (req_a_o),
    .req_b_o   (req_b_o),
    .loc_a_o   (loc_a_o),
    .loc_b_o   (loc_b_o),
    .clkval_a_o(clkval_a_o),
    .clkval_b_o(clkval_b_o)
);

// File: tb/ta_pair_core_tb_top.sv
module ta_pair_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW   = 4;
    localparam int SUB  = 4;
    localparam int MASK = (1 << TW) - 1;
    localparam int RUN  = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          tick   [2];
    logic [TW-1:0] now    [2];
    logic          ack    [2];
    logic          req_a  [2];
    logic          req_b  [2];
    logic [1:0]    loc_a  [2];
    logic [1:0]    loc_b  [2];
    logic [TW-1:0] cval_a [2];
    logic [TW-1:0] cval_b [2];

    // Equal guards
    ta_pair_core #(.TIME_W(TW), .SUB_CYCLES(SUB), .GUARD_A(2), .GUARD_B(2)) dut_i (
        .clk(clk), .rst(rst), .tick_o(tick[0]), .now_time_o(now[0]), .chan_ack_o(ack[0]),
        .req_a_o(req_a[0]), .req_b_o(req_b[0]), .loc_a_o(loc_a[0]), .loc_b_o(loc_b[0]),
        .clkval_a_o(cval_a[0]), .clkval_b_o(cval_b[0]));

    // Unequal guards (R9)
    ta_pair_core #(.TIME_W(TW), .SUB_CYCLES(SUB), .GUARD_A(2), .GUARD_B(3)) dut_u (
        .clk(clk), .rst(rst), .tick_o(tick[1]), .now_time_o(now[1]), .chan_ack_o(ack[1]),
        .req_a_o(req_a[1]), .req_b_o(req_b[1]), .loc_a_o(loc_a[1]), .loc_b_o(loc_b[1]),
        .clkval_a_o(cval_a[1]), .clkval_b_o(cval_b[1]));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state: per design d, per automaton j
    int m_sub [2];
    int m_now [2];
    bit m_ack [2];
    int m_loc [2][2];
    int m_cap [2][2];
    int m_grd [2][2];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_req(input int d, input int j);
        return (m_loc[d][j] == 1) && !m_ack[d];
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_sub[d] = 0; m_now[d] = 0; m_ack[d] = 1'b0;
            for (int j = 0; j < 2; j++) begin
                m_loc[d][j] = 1; m_cap[d][j] = 0;
            end
        end
        m_grd[0][0] = 2; m_grd[0][1] = 2;
        m_grd[1][0] = 2; m_grd[1][1] = 3;
    endtask

    task automatic model_step();
        for (int d = 0; d < 2; d++) begin
            bit tk = (m_sub[d] == SUB - 1);
            bit r0 = m_req(d, 0);
            bit r1 = m_req(d, 1);
            if (!tk) begin
                for (int j = 0; j < 2; j++) begin
                    int el = (m_now[d] - m_cap[d][j]) & MASK;
                    if (m_loc[d][j] == 1 && m_ack[d]) begin
                        m_loc[d][j] = 2; m_cap[d][j] = m_now[d];
                    end else if (m_loc[d][j] == 2 && el == m_grd[d][j]) begin
                        m_loc[d][j] = 1;
                    end
                end
            end
            m_ack[d] = r0 && r1;
            if (tk) begin
                m_now[d] = (m_now[d] + 1) & MASK;
                m_sub[d] = 0;
            end else begin
                m_sub[d] = m_sub[d] + 1;
            end
        end
    endtask

    task automatic compare_all();
        for (int d = 0; d < 2; d++) begin
            check(tick[d] == (m_sub[d] == SUB - 1), "R2 tick", int'(tick[d]), int'(m_sub[d] == SUB - 1));
            check(int'(now[d]) == m_now[d], "R3 global time", int'(now[d]), m_now[d]);
            check(ack[d] == m_ack[d], "R4 acknowledge", int'(ack[d]), int'(m_ack[d]));
            check(req_a[d] == m_req(d, 0), "R5 request A", int'(req_a[d]), int'(m_req(d, 0)));
            check(req_b[d] == m_req(d, 1), "R5 request B", int'(req_b[d]), int'(m_req(d, 1)));
            check(int'(loc_a[d]) == m_loc[d][0], "R6 location A", int'(loc_a[d]), m_loc[d][0]);
            check(int'(loc_b[d]) == m_loc[d][1], "R6 location B", int'(loc_b[d]), m_loc[d][1]);
            check(int'(cval_a[d]) == ((m_now[d] - m_cap[d][0]) & MASK), "R3 clock A",
                  int'(cval_a[d]), (m_now[d] - m_cap[d][0]) & MASK);
            check(int'(cval_b[d]) == ((m_now[d] - m_cap[d][1]) & MASK), "R3 clock B",
                  int'(cval_b[d]), (m_now[d] - m_cap[d][1]) & MASK);
            check(loc_a[d] != 2'b11 && loc_a[d] != 2'b00 && loc_b[d] != 2'b11 && loc_b[d] != 2'b00,
                  "R8 legal codes", int'({loc_a[d], loc_b[d]}), 0);
        end
    endtask

    initial begin
        int waits_seen = 0;
        int wraps_seen = 0;
        bit pa, pb;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, cycle 0
        check(now[0] == '0 && cval_a[0] == '0 && cval_b[0] == '0, "R1 zero time/clocks",
              int'(now[0]) + int'(cval_a[0]) + int'(cval_b[0]), 0);
        check(loc_a[0] == 2'b01 && loc_b[0] == 2'b01, "R1 wait location",
              int'({loc_a[0], loc_b[0]}), 5);
        check(!ack[0] && !tick[0], "R1 ack/tick low", int'({ack[0], tick[0]}), 0);
        compare_all();
        for (int cyc = 1; cyc <= RUN; cyc++) begin
            pa = (loc_a[1] == 2'b01);
            pb = (loc_b[1] == 2'b01);
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
            // Directed points derived by hand for equal guards of 2 and a period of 4
            if (cyc == 3) check(tick[0], "R2 first tick at cycle 3", int'(tick[0]), 1);
            if (cyc == 4) check(now[0] == 4'd1, "R2 time 1 at cycle 4", int'(now[0]), 1);
            if (cyc == 1) check(ack[0] && !req_a[0], "R4 ack one cycle after requests",
                                int'({ack[0], req_a[0]}), 2);
            if (cyc == 2) check(loc_a[0] == 2'b10 && cval_a[0] == '0, "R5 hold entered at cycle 2",
                                int'(loc_a[0]), 2);
            if (cyc == 8) check(cval_a[0] == 4'd2 && loc_a[0] == 2'b10, "R6 guard reached at cycle 8",
                                int'(cval_a[0]), 2);
            if (cyc == 9) check(loc_a[0] == 2'b01 && req_a[0], "R6 back to wait at cycle 9",
                                int'(loc_a[0]), 1);
            if (cyc == 11) check(loc_a[0] == 2'b10, "R7 capture on third sub-cycle", int'(loc_a[0]), 2);
            if (cyc == 64) begin
                check(now[0] == '0, "R3 wrap at cycle 64", int'(now[0]), 0);
                wraps_seen++;
            end
            // R9: A waits with request high while B still holds
            if (loc_a[1] == 2'b01 && loc_b[1] == 2'b10) begin
                waits_seen++;
                check(req_a[1], "R9 faster automaton keeps request", int'(req_a[1]), 1);
            end
            if ((pa && loc_a[1] == 2'b10) || (pb && loc_b[1] == 2'b10))
                check((pa && loc_a[1] == 2'b10) && (pb && loc_b[1] == 2'b10),
                      "R9 joint departure", int'({loc_a[1], loc_b[1]}), 10);
        end
        check(waits_seen > 0, "R9 waiting observed", waits_seen, 1);
        check(wraps_seen == 1, "R3 wrap observed", wraps_seen, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule